// File: doc/BRIEF.md
# Burst CAS and Acknowledge Strobe Generator

This block times the column strobe (CAS, active low) and a data-acknowledge strobe for every access of a DRAM burst. A start pulse opens a burst. The opening access lasts a programmed number of clocks. Each later access lasts a separately programmed number of clocks. Between accesses CAS is released for a precharge gap. The gap has its own setting for reads and for writes, and the read setting includes a half-clock gap. The acknowledge is a one-clock pulse in the last clock of each access. The burst goes on while the burst request is high in that clock and stops after the first acknowledge during which it is low. A one-clock done pulse then marks the end of the burst.

A select bit moves both strobes from the rising clock edge to the falling clock edge. The sequencing runs entirely on the rising edge. A small retiming stage, clocked on the falling edge, produces the half-clock placements. No clock is gated. Address generation and RAS control are handled by neighbouring logic.

Top module: `burst_strobe_gen`

## Requirements
- R1: While reset is low, and in every idle clock, cas_n is 1, ack is 0 and done is 0.
- R2: In idle, start sampled high at a rising edge asserts CAS from that edge for an opening access of cfg_open_len clocks (a value of 0 acts as 1). ack is high only during the last clock of that access.
- R3: Every later access of the burst keeps CAS low for cfg_burst_len clocks (0 acts as 1), with ack high in its last clock.
- R4: burst_req high at the edge that ends an acknowledged access starts a precharge gap. burst_req low at that edge releases CAS and ends the burst, and done is then high for exactly the following clock. done always changes on the rising edge.
- R5: For a read burst the precharge gap is one clock when cfg_rd_half is 0. When cfg_rd_half is 1 the gap is half a clock: CAS is released on the edge opposite the selected one, and is asserted again on the selected edge.
- R6: For a write burst the precharge gap is one clock when cfg_wr_two is 0 and two clocks when cfg_wr_two is 1.
- R7: With cfg_fall_edge at 0, cas_n and ack change on rising edges. With cfg_fall_edge at 1, every change of cas_n and ack moves half a clock later, onto the falling edge.
- R8: start is ignored while a burst is running. is_write is sampled only together with an accepted start, so changing it during a burst does not change the precharge gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a burst when idle |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| burst_req | input | 1 | Keep bursting after the current access |
| cfg_open_len | input | LEN_W | Opening access length in clocks |
| cfg_burst_len | input | LEN_W | Later access length in clocks |
| cfg_rd_half | input | 1 | Read precharge: 1 = half clock, 0 = one clock |
| cfg_wr_two | input | 1 | Write precharge: 1 = two clocks, 0 = one clock |
| cfg_fall_edge | input | 1 | 1 = strobes change on the falling edge |
| cas_n | output | 1 | Column strobe, active low |
| ack | output | 1 | Data acknowledge pulse |
| done | output | 1 | One-clock end-of-burst pulse |

## Verification
Two events can land in the same clock. The first is the acknowledge of the final access, the point where the sequencer decides whether to end the burst. The second is a new start pulse, which could be taken as a fresh burst. The bench drives start in that final acknowledge clock, and once more early in the burst, and it also toggles is_write during the burst. It judges the result by comparing cas_n, ack and done, in both halves of every clock, against a waveform built from the burst plan alone. Any extra access or a changed precharge gap shows up as a mismatch.

// File: rtl/burst_strobe_pkg.sv
`timescale 1ns/1ps
package burst_strobe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACC  = 2'd1,
    PH_PRE  = 2'd2
  } phase_t;

  // A programmed length of zero is taken as a single clock.
  function automatic int eff_len(input int field);
    return (field == 0) ? 1 : field;
  endfunction

  // Number of whole core clocks CAS stays released between accesses.
  // A half-clock read gap still occupies one core clock; the retiming
  // stage trims it.
  function automatic int pre_len(input logic wr, input logic wr_two);
    return wr ? (wr_two ? 2 : 1) : 1;
  endfunction

endpackage

// File: rtl/bsg_sequencer.sv
`timescale 1ns/1ps
module bsg_sequencer
  import burst_strobe_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             burst_req,
  input  logic [LEN_W-1:0] cfg_open_len,
  input  logic [LEN_W-1:0] cfg_burst_len,
  input  logic             cfg_rd_half,
  input  logic             cfg_wr_two,
  output logic             cas_core_n,
  output logic             ack_core,
  output logic             done_core,
  output logic             hold_core,
  output logic             acc_end
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_t           st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             wr_q, wr_d;
  logic [LEN_W-1:0] len_cur, len_nxt, gap_len;
  logic             pre_end;

  assign len_cur = LEN_W'(eff_len(first_q ? int'(cfg_open_len) : int'(cfg_burst_len)));
  assign len_nxt = LEN_W'(eff_len(first_d ? int'(cfg_open_len) : int'(cfg_burst_len)));
  assign gap_len = LEN_W'(pre_len(wr_q, cfg_wr_two));

  assign acc_end = (st_q == PH_ACC) && (cnt_q == len_cur);
  assign pre_end = (st_q == PH_PRE) && (cnt_q == gap_len);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    wr_d    = wr_q;
    case (st_q)
      PH_IDLE: begin
        if (start) begin
          st_d    = PH_ACC;
          cnt_d   = ONE;
          first_d = 1'b1;
          wr_d    = is_write;
        end
      end
      PH_ACC: begin
        if (acc_end) begin
          if (burst_req) begin
            st_d  = PH_PRE;
            cnt_d = ONE;
          end else begin
            st_d = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_PRE: begin
        if (pre_end) begin
          st_d    = PH_ACC;
          cnt_d   = ONE;
          first_d = 1'b0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PH_IDLE;
      cnt_q      <= '0;
      first_q    <= 1'b0;
      wr_q       <= 1'b0;
      cas_core_n <= 1'b1;
      ack_core   <= 1'b0;
      done_core  <= 1'b0;
      hold_core  <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      first_q    <= first_d;
      wr_q       <= wr_d;
      cas_core_n <= (st_d != PH_ACC);
      ack_core   <= (st_d == PH_ACC) && (cnt_d == len_nxt);
      done_core  <= acc_end && !burst_req;
      hold_core  <= (st_d == PH_PRE) && (cnt_d == ONE) && !wr_d && cfg_rd_half;
    end
  end

endmodule

// File: rtl/bsg_edge_out.sv
`timescale 1ns/1ps
module bsg_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_sel,
  input  logic cas_core_n,
  input  logic hold_core,
  input  logic ack_core,
  output logic cas_n,
  output logic ack
);

  logic cas_f, hold_f, ack_f;  // half-clock copies
  logic cas_r2;                // one-clock copy

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_f  <= 1'b1;
      hold_f <= 1'b0;
      ack_f  <= 1'b0;
    end else begin
      cas_f  <= cas_core_n;
      hold_f <= hold_core;
      ack_f  <= ack_core;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cas_r2 <= 1'b1;
    else        cas_r2 <= cas_core_n;
  end

  // In a half-gap clock the strobe stays asserted for its first half,
  // which moves the release onto the opposite edge.
  always_comb begin
    if (fall_sel) begin
      cas_n = cas_f & (cas_r2 | ~hold_f);
      ack   = ack_f;
    end else begin
      cas_n = cas_core_n & (cas_f | ~hold_core);
      ack   = ack_core;
    end
  end

endmodule

// File: rtl/burst_strobe_gen.sv
`timescale 1ns/1ps
module burst_strobe_gen
  import burst_strobe_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             burst_req,
  input  logic [LEN_W-1:0] cfg_open_len,
  input  logic [LEN_W-1:0] cfg_burst_len,
  input  logic             cfg_rd_half,
  input  logic             cfg_wr_two,
  input  logic             cfg_fall_edge,
  output logic             cas_n,
  output logic             ack,
  output logic             done
);

  // Named internal events, also watched by the checker.
  logic core_cas_n;
  logic core_ack;
  logic core_done;
  logic core_hold;
  logic acc_end;

  bsg_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .is_write     (is_write),
    .burst_req    (burst_req),
    .cfg_open_len (cfg_open_len),
    .cfg_burst_len(cfg_burst_len),
    .cfg_rd_half  (cfg_rd_half),
    .cfg_wr_two   (cfg_wr_two),
    .cas_core_n   (core_cas_n),
    .ack_core     (core_ack),
    .done_core    (core_done),
    .hold_core    (core_hold),
    .acc_end      (acc_end)
  );

  bsg_edge_out u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_sel  (cfg_fall_edge),
    .cas_core_n(core_cas_n),
    .hold_core (core_hold),
    .ack_core  (core_ack),
    .cas_n     (cas_n),
    .ack       (ack)
  );

  assign done = core_done;

endmodule

// File: rtl/bsg_checker.sv
`timescale 1ns/1ps
module bsg_checker (
  input logic clk,
  input logic rst_n,
  input logic burst_req,
  input logic core_cas_n,
  input logic core_ack,
  input logic core_done,
  input logic core_hold,
  input logic acc_end
);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> !core_ack);

  // R2
  ack_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |-> !core_cas_n);

  // R3
  ack_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack == acc_end);

  // R4
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && !burst_req) |=> (core_done && core_cas_n));

  // R4
  go_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && burst_req) |=> (core_cas_n && !core_done));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  // R5
  hold_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold |-> (core_cas_n && $past(!core_cas_n)));

endmodule

bind burst_strobe_gen bsg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .burst_req (burst_req),
  .core_cas_n(core_cas_n),
  .core_ack  (core_ack),
  .core_done (core_done),
  .core_hold (core_hold),
  .acc_end   (acc_end)
);

// File: tb/tb_burst_strobe_gen.sv
`timescale 1ns/1ps
module tb_burst_strobe_gen;

  localparam int LEN_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             is_write = 1'b0;
  logic             burst_req = 1'b0;
  logic [LEN_W-1:0] cfg_open_len = '0;
  logic [LEN_W-1:0] cfg_burst_len = '0;
  logic             cfg_rd_half = 1'b0;
  logic             cfg_wr_two = 1'b0;
  logic             cfg_fall_edge = 1'b0;
  logic             cas_n, ack, done;

  always #5 clk = ~clk;

  burst_strobe_gen #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .burst_req(burst_req), .cfg_open_len(cfg_open_len),
    .cfg_burst_len(cfg_burst_len), .cfg_rd_half(cfg_rd_half),
    .cfg_wr_two(cfg_wr_two), .cfg_fall_edge(cfg_fall_edge),
    .cas_n(cas_n), .ack(ack), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Planned core-clock waveform of one burst.
  bit r_t  [0:63];
  bit hd_t [0:63];
  bit ak_t [0:63];
  bit dn_t [0:63];
  bit br_t [0:63];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic run_burst(input string tag, input bit wr, input int open_f, input int burst_f,
                           input bit half, input bit two, input bit fall, input int n_acc,
                           input bit disturb);
    int eo;
    int eb;
    int c;
    int last_acc;
    eo = (open_f == 0) ? 1 : open_f;
    eb = (burst_f == 0) ? 1 : burst_f;
    for (int i = 0; i < 64; i++) begin
      r_t[i] = 1; hd_t[i] = 0; ak_t[i] = 0; dn_t[i] = 0; br_t[i] = 0;
    end
    c = 1;
    for (int k = 0; k < n_acc; k++) begin
      int len;
      len = (k == 0) ? eo : eb;
      for (int i = 1; i <= len; i++) begin
        r_t[c] = 0;
        ak_t[c] = (i == len);
        br_t[c] = (k < n_acc - 1);
        c++;
      end
      if (k < n_acc - 1) begin
        int p;
        p = wr ? (two ? 2 : 1) : 1;
        for (int i = 1; i <= p; i++) begin
          hd_t[c] = (i == 1) && !wr && half;
          c++;
        end
      end
    end
    last_acc = c - 1;
    dn_t[c] = 1;
    c += 3;
    for (int cy = 0; cy < c; cy++) begin
      bit rp, rc, hc, ap, ac;
      @(posedge clk);
      #1;
      start         = (cy == 0) || (disturb && (cy == 2 || cy == last_acc));
      is_write      = (cy == 0) ? wr : (disturb ? ~wr : wr);
      burst_req     = br_t[cy];
      cfg_open_len  = LEN_W'(open_f);
      cfg_burst_len = LEN_W'(burst_f);
      cfg_rd_half   = half;
      cfg_wr_two    = two;
      cfg_fall_edge = fall;
      rp = (cy == 0) ? 1'b1 : r_t[cy-1];
      ap = (cy == 0) ? 1'b0 : ak_t[cy-1];
      rc = r_t[cy];
      hc = hd_t[cy];
      ac = ak_t[cy];
      #1.5;
      chk(tag,  "cas_n first half", cas_n, fall ? rp : (rc & (rp | ~hc)));
      chk("R2", "ack first half",   ack,   fall ? ap : ac);
      chk("R4", "done first half",  done,  dn_t[cy]);
      #5;
      chk(tag,  "cas_n second half", cas_n, fall ? (rc & (rp | ~hc)) : rc);
      chk("R2", "ack second half",   ack,   ac);
      chk("R4", "done second half",  done,  dn_t[cy]);
    end
    start = 1'b0;
    burst_req = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2.5;
    // R1 reset state
    chk("R1", "cas_n in reset", cas_n, 1'b1);
    chk("R1", "ack in reset",   ack,   1'b0);
    chk("R1", "done in reset",  done,  1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2.5;
    chk("R1", "cas_n idle", cas_n, 1'b1);
    chk("R1", "ack idle",   ack,   1'b0);

    // read, half gap, rising edge, four accesses
    run_burst("R5", 1'b0, 3, 2, 1'b1, 1'b0, 1'b0, 4, 1'b0);
    // read, one-clock gap, falling edge
    run_burst("R7", 1'b0, 3, 2, 1'b0, 1'b0, 1'b1, 3, 1'b0);
    // write, two-clock gap, stray starts and is_write toggles
    run_burst("R8", 1'b1, 3, 2, 1'b0, 1'b1, 1'b0, 3, 1'b1);
    // write, one-clock gap, falling edge
    run_burst("R6", 1'b1, 2, 3, 1'b0, 1'b0, 1'b1, 2, 1'b0);
    // read, half gap on falling edge, single-clock accesses
    run_burst("R3", 1'b0, 1, 1, 1'b1, 1'b0, 1'b1, 3, 1'b0);
    // single access, zero length field acts as one
    run_burst("R2", 1'b0, 0, 4, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    // write, two-clock gap, falling edge, long later accesses
    run_burst("R6", 1'b1, 3, 4, 1'b1, 1'b1, 1'b1, 3, 1'b0);
    // read, half gap, rising edge, stray starts
    run_burst("R8", 1'b0, 2, 2, 1'b1, 1'b1, 1'b0, 3, 1'b1);

    @(posedge clk);
    #2.5;
    chk("R1", "cas_n idle at end", cas_n, 1'b1);
    summary();
    $finish;
  end

endmodule